// File: doc/BRIEF.md
# Critical-Conduction Boost PFC Gate Timer

This block produces the gate command for the switch of a boost power-factor stage. The stage runs at the boundary between continuous and discontinuous conduction. Each switching cycle drives the gate high for an on-time count supplied by the voltage control loop. The gate then stays low while the inductor demagnetises. The inductor's auxiliary winding provides a zero-current flag that has already been digitised and synchronised. When the flag goes high it marks the demagnetising interval. When it goes low again, the inductor current has reached zero and the next on-time starts on the following clock edge.

The block also handles the cases where that sequence does not arrive. A watchdog counter restarts every time the gate turns on. If no valid zero-current sequence is seen before the watchdog expires, the block forces a pulse of the programmed length, and it keeps doing so until a proper sequence returns. Two flags from the bus comparators provide overvoltage protection with hysteresis: a trip flag blocks switching, and a release flag later resumes switching with one forced pulse. An enable from the mode sequencer gates everything off during fault or lockout. When the rectified line is near a zero-crossing, a flag lengthens the on-time to reduce crossover distortion. The effective on-time is always clamped to a safe maximum.

Top module: `crm_pfc_gate_timer`

## Requirements
- R1: After each turn-on, `gate` stays high for exactly the effective on-time in clock cycles and then goes low.
- R2: The effective on-time is `ton_req` when `near_zc` is low. It is `ton_req + (ton_req >> STRETCH_SHIFT)` when `near_zc` is high. The value is captured on the turn-on edge.
- R3: The effective on-time is clamped to the range 1 to `MAX_ON` cycles. A request of zero gives a 1-cycle pulse, and any larger result gives `MAX_ON`.
- R4: During the off-time, a high level of `zc_flag` followed by a low level turns the gate on at the first clock edge that samples the low level. The gate does not turn on earlier.
- R5: A high-to-low transition of `zc_flag` during the off-time is ignored if it was not preceded by a low-to-high transition in that same off-time. A rise that occurs while the gate is on does not count.
- R6: If no valid sequence ends the off-time, the gate is forced on exactly `WDOG_CYCLES` clock cycles after the previous turn-on. This repeats for as long as no valid sequence occurs, including while `zc_flag` is stuck high.
- R7: After forced pulses, a valid rise-then-fall of `zc_flag` turns the gate on again at once (normal operation).
- R8: While `ovp_trip` is high, the gate is low from the next clock edge, and any pulse in progress is cut short.
- R9: After a trip, the gate stays low until `ovp_clear` is high with `ovp_trip` low. `ovp_trip` going low on its own does not resume switching. `ovp_clear` has no effect outside the tripped condition.
- R10: On release, a forced pulse of the effective on-time begins at the next clock edge, and the watchdog interval restarts from that turn-on.
- R11: While `enable` is low, the gate is low from the next clock edge, and it stays low for any length of time.
- R12: When `enable` returns high with `ovp_trip` low, a pulse starts at the next clock edge.
- R13: During and right after reset, the gate is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run permission from the mode sequencer |
| ton_req | input | CNT_W | Requested on-time in clock cycles |
| near_zc | input | 1 | Rectified line is near a zero-crossing; stretches the on-time |
| zc_flag | input | 1 | Synchronised zero-current flag from the auxiliary winding |
| ovp_trip | input | 1 | Bus above the overvoltage trip level |
| ovp_clear | input | 1 | Bus below the overvoltage release level |
| gate | output | 1 | Gate command for the boost switch |

## Verification
The bench builds the block with CNT_W = 8, MAX_ON = 150, WDOG_CYCLES = 200 and STRETCH_SHIFT = 2. A watchdog interval of 200 cycles lets the bench measure several forced-pulse periods exactly, and also observe overvoltage and disable holds longer than the watchdog, well within the run length. An 8-bit request with a cap of 150 means both the plain request and the stretched request cross the clamp. This allows the boundary values 120, 121, 150 and 255, as well as zero, to be driven directly.

// File: rtl/pfc_gate_pkg.sv
package pfc_gate_pkg;

   // Controller states of the gate timer
   typedef enum logic [2:0] {
      PG_IDLE  = 3'd0,   // not permitted to switch
      PG_ON    = 3'd1,   // gate high, on-time running
      PG_ARM   = 3'd2,   // off-time, waiting for flag to rise
      PG_DEMAG = 3'd3,   // off-time, flag seen high, waiting for fall
      PG_OVP   = 3'd4    // bus overvoltage hold
   } pg_state_e;

endpackage

// File: rtl/pfc_zc_edge.sv
module pfc_zc_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic zc_flag,
   output logic zc_rise,
   output logic zc_fall
);

   logic zc_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) zc_prev_q <= 1'b0;
      else        zc_prev_q <= zc_flag;
   end

   assign zc_rise =  zc_flag & ~zc_prev_q;
   assign zc_fall = ~zc_flag &  zc_prev_q;

endmodule

// File: rtl/pfc_ontime_calc.sv
module pfc_ontime_calc #(
   parameter int CNT_W         = 10,
   parameter int MAX_ON        = 800,
   parameter int STRETCH_SHIFT = 2
) (
   input  logic [CNT_W-1:0] ton_req,
   input  logic             near_zc,
   output logic [CNT_W-1:0] on_eff
);

   localparam int EXT_W = CNT_W + 1;
   localparam logic [EXT_W-1:0] MAX_EXT = EXT_W'(MAX_ON);

   logic [EXT_W-1:0] stretch_ext;
   logic [EXT_W-1:0] base_ext;

   generate
      if (STRETCH_SHIFT == 0) begin : g_no_stretch
         assign stretch_ext = '0;
      end else begin : g_stretch
         assign stretch_ext = near_zc ? EXT_W'(ton_req >> STRETCH_SHIFT) : '0;
      end
   endgenerate

   assign base_ext = {1'b0, ton_req} + stretch_ext;

   always_comb begin
      if (base_ext == '0)          on_eff = CNT_W'(1);
      else if (base_ext > MAX_EXT) on_eff = CNT_W'(MAX_ON);
      else                         on_eff = base_ext[CNT_W-1:0];
   end

endmodule

// File: rtl/pfc_on_timer.sv
module pfc_on_timer #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_len,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_len - CNT_W'(1);
      else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
   end

   assign last = (cnt_q == '0);

endmodule

// File: rtl/pfc_wdog_timer.sv
module pfc_wdog_timer #(
   parameter int WDOG_CYCLES = 40000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic expired
);

   localparam int WD_W = $clog2(WDOG_CYCLES);
   localparam logic [WD_W-1:0] WD_LAST = WD_W'(WDOG_CYCLES - 1);

   logic [WD_W-1:0] wd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              wd_q <= '0;
      else if (restart)        wd_q <= '0;
      else if (wd_q != WD_LAST) wd_q <= wd_q + WD_W'(1);
   end

   assign expired = (wd_q == WD_LAST);

endmodule

// File: rtl/crm_pfc_gate_timer.sv
module crm_pfc_gate_timer
   import pfc_gate_pkg::*;
#(
   parameter int CNT_W         = 10,
   parameter int MAX_ON        = 800,
   parameter int WDOG_CYCLES   = 40000,
   parameter int STRETCH_SHIFT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [CNT_W-1:0] ton_req,
   input  logic             near_zc,
   input  logic             zc_flag,
   input  logic             ovp_trip,
   input  logic             ovp_clear,
   output logic             gate
);

   // Elaboration-time parameter checks
   generate
      if (MAX_ON < 1 || MAX_ON >= (1 << CNT_W)) begin : g_bad_max_on
         $error("MAX_ON must be in 1 .. 2**CNT_W-1");
      end
      if (WDOG_CYCLES <= MAX_ON + 1) begin : g_bad_wdog
         $error("WDOG_CYCLES must exceed MAX_ON + 1");
      end
      if (STRETCH_SHIFT < 0 || STRETCH_SHIFT >= CNT_W) begin : g_bad_shift
         $error("STRETCH_SHIFT must be in 0 .. CNT_W-1");
      end
   endgenerate

   pg_state_e        state_q, state_d;
   logic             start_on;
   logic             zc_rise, zc_fall;
   logic             on_last;
   logic             wd_expired;
   logic [CNT_W-1:0] on_eff;

   pfc_zc_edge u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .zc_flag (zc_flag),
      .zc_rise (zc_rise),
      .zc_fall (zc_fall)
   );

   pfc_ontime_calc #(
      .CNT_W         (CNT_W),
      .MAX_ON        (MAX_ON),
      .STRETCH_SHIFT (STRETCH_SHIFT)
   ) u_calc (
      .ton_req (ton_req),
      .near_zc (near_zc),
      .on_eff  (on_eff)
   );

   pfc_on_timer #(
      .CNT_W (CNT_W)
   ) u_on (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start_on),
      .load_len (on_eff),
      .last     (on_last)
   );

   pfc_wdog_timer #(
      .WDOG_CYCLES (WDOG_CYCLES)
   ) u_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (start_on),
      .expired (wd_expired)
   );

   // Next-state: disable beats overvoltage beats normal sequencing
   always_comb begin
      state_d  = state_q;
      start_on = 1'b0;
      if (!enable) begin
         state_d = PG_IDLE;
      end else if (ovp_trip) begin
         state_d = PG_OVP;
      end else begin
         unique case (state_q)
            PG_IDLE:  start_on = 1'b1;
            PG_ON:    if (on_last) state_d = PG_ARM;
            PG_ARM: begin
               if (wd_expired)   start_on = 1'b1;
               else if (zc_rise) state_d  = PG_DEMAG;
            end
            PG_DEMAG: if (zc_fall || wd_expired) start_on = 1'b1;
            PG_OVP:   if (ovp_clear) start_on = 1'b1;
            default:  state_d = PG_IDLE;
         endcase
         if (start_on) state_d = PG_ON;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PG_IDLE;
      else        state_q <= state_d;
   end

   assign gate = (state_q == PG_ON);

endmodule

// File: rtl/pfc_gate_timer_chk.sv
module pfc_gate_timer_chk #(
   parameter int MAX_ON      = 800,
   parameter int WDOG_CYCLES = 40000
) (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic ovp_trip,
   input logic ovp_clear,
   input logic gate
);

   int   hi_run;
   int   lo_gap;
   logic ovp_lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run  <= 0;
         lo_gap  <= 0;
         ovp_lat <= 1'b0;
      end else begin
         hi_run <= gate ? hi_run + 1 : 0;
         lo_gap <= (gate || !enable || ovp_trip || ovp_lat) ? 0 : lo_gap + 1;
         if (!enable)                     ovp_lat <= 1'b0;
         else if (ovp_trip)               ovp_lat <= 1'b1;
         else if (ovp_clear)              ovp_lat <= 1'b0;
      end
   end

   assert_disable_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !gate);

   assert_ovp_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ovp_trip |=> !gate);

   assert_on_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      gate |-> (hi_run < MAX_ON));

   assert_wdog_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lo_gap <= WDOG_CYCLES);

   assert_ovp_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ovp_lat && enable && !ovp_trip && ovp_clear) |=> gate);

endmodule

bind crm_pfc_gate_timer pfc_gate_timer_chk #(
   .MAX_ON      (MAX_ON),
   .WDOG_CYCLES (WDOG_CYCLES)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .enable    (enable),
   .ovp_trip  (ovp_trip),
   .ovp_clear (ovp_clear),
   .gate      (gate)
);

// File: tb/crm_pfc_gate_timer_tb_top.sv
`timescale 1ns/1ps
module crm_pfc_gate_timer_tb_top;

   localparam int CNT_W  = 8;
   localparam int MAX_ON = 150;
   localparam int WDOG   = 200;
   localparam int SHIFT  = 2;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             enable;
   logic [CNT_W-1:0] ton_req;
   logic             near_zc;
   logic             zc_flag;
   logic             ovp_trip;
   logic             ovp_clear;
   logic             gate;

   int n_run  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   crm_pfc_gate_timer #(
      .CNT_W (CNT_W), .MAX_ON (MAX_ON),
      .WDOG_CYCLES (WDOG), .STRETCH_SHIFT (SHIFT)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .enable (enable), .ton_req (ton_req),
      .near_zc (near_zc), .zc_flag (zc_flag), .ovp_trip (ovp_trip),
      .ovp_clear (ovp_clear), .gate (gate)
   );

   function automatic int exp_on(int ton, bit near);
      int b = ton + (near ? (ton >> SHIFT) : 0);
      if (b == 0) return 1;
      if (b > MAX_ON) return MAX_ON;
      return b;
   endfunction

   task automatic check(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // negedges until gate is seen high
   task automatic wait_rise(output int n);
      n = 0;
      while (gate !== 1'b1 && n < 1000) begin
         tick();
         n++;
      end
   endtask

   // gate is high at this negedge; count high negedges
   task automatic measure_width(output int w);
      w = 1;
      forever begin
         tick();
         if (gate === 1'b1 && w < 1000) w++;
         else break;
      end
   endtask

   // count high samples over a window
   task automatic count_high(input int cycles, output int hi);
      hi = 0;
      for (int i = 0; i < cycles; i++) begin
         tick();
         if (gate === 1'b1) hi++;
      end
   endtask

   // valid rise-then-fall, then check turn-on timing and width
   task automatic pulse_zc(input int ton, input bit near, input string req);
      int w;
      ton_req = CNT_W'(ton);
      near_zc = near;
      zc_flag = 1'b1;
      tick();
      tick();
      check("R4 no early turn-on", int'(gate), 0);
      zc_flag = 1'b0;
      tick();
      check("R4 turn-on after fall", int'(gate), 1);
      measure_width(w);
      check(req, w, exp_on(ton, near));
   endtask

   initial begin
      int w, n, hi, t;
      bit nz;
      void'($urandom(32'h0005_eed1));
      rst_n = 1'b0; enable = 1'b0; ton_req = 8'd20; near_zc = 1'b0;
      zc_flag = 1'b0; ovp_trip = 1'b0; ovp_clear = 1'b0;
      repeat (4) tick();
      check("R13 gate low in reset", int'(gate), 0);
      rst_n = 1'b1;
      count_high(5, hi);
      check("R11 gate low, enable low after reset", hi, 0);

      // R12 kick start
      enable = 1'b1;
      tick();
      check("R12 kick on enable", int'(gate), 1);
      measure_width(w);
      check("R1 kick width", w, 20);

      // directed widths
      pulse_zc(40, 1'b0, "R1 plain width");
      pulse_zc(40, 1'b1, "R2 stretched width");
      pulse_zc(0, 1'b0, "R3 zero request");
      pulse_zc(150, 1'b0, "R3 at max");
      pulse_zc(255, 1'b1, "R3 clamp high");
      pulse_zc(121, 1'b1, "R3 stretch over max");
      pulse_zc(120, 1'b1, "R3 stretch at max");

      // random mix
      for (int k = 0; k < 24; k++) begin
         t  = int'($urandom_range(0, 255));
         nz = 1'($urandom_range(0, 1));
         pulse_zc(t, nz, "R2 random width");
      end

      // R5: rise during ON, fall in off-time -> ignored, watchdog fires
      ton_req = 8'd30; near_zc = 1'b0;
      zc_flag = 1'b1; tick(); tick();
      zc_flag = 1'b0; tick();
      check("R4 turn-on", int'(gate), 1);
      zc_flag = 1'b1;
      measure_width(w);
      zc_flag = 1'b0;
      wait_rise(n);
      check("R5 lone fall ignored, R6 period", w + n, WDOG);
      measure_width(w);
      wait_rise(n);
      check("R6 repeated watchdog period", w + n, WDOG);
      // R6 with flag stuck high during off-time
      zc_flag = 1'b1;
      measure_width(w);
      wait_rise(n);
      check("R6 watchdog with flag stuck high", w + n, WDOG);
      zc_flag = 1'b0;          // fall during ON: ignored
      measure_width(w);
      check("R1 forced width", w, 30);
      pulse_zc(25, 1'b0, "R7 resume normal width");

      // R8/R9/R10 overvoltage
      ton_req = 8'd100;
      zc_flag = 1'b1; tick(); tick();
      zc_flag = 1'b0; tick();
      check("R4 turn-on before trip", int'(gate), 1);
      repeat (5) tick();
      ovp_trip = 1'b1;
      tick();
      check("R8 trip cuts pulse", int'(gate), 0);
      count_high(10, hi);
      ovp_trip = 1'b0;
      count_high(300, n);
      check("R9 hold without release", hi + n, 0);
      ovp_clear = 1'b1;
      tick();
      check("R10 forced pulse on release", int'(gate), 1);
      measure_width(w);
      check("R10 release pulse width", w, 100);
      wait_rise(n);
      check("R10 watchdog restarts, R9 clear ignored", w + n, WDOG);
      ovp_clear = 1'b0;

      // R11/R12 enable
      enable = 1'b0;
      tick();
      check("R11 disable cuts pulse", int'(gate), 0);
      count_high(300, hi);
      check("R11 stays low", hi, 0);
      enable = 1'b1;
      tick();
      check("R12 kick after re-enable", int'(gate), 1);
      measure_width(w);
      check("R1 re-enable width", w, 100);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #750000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule